// File: doc/BRIEF.md
# Custom Instruction Dispatch and Stall Control

This block sits in the decode/execute path of a pipelined processor and handles the instructions reserved for user-defined extensions. It looks at each offered 32-bit instruction word and matches its 7-bit major opcode against the custom code `0001011`. The word uses an R-type layout: funct7 in bits 31:25, the second source address in 24:20, the first source address in 19:15, funct3 in 14:12, the destination address in 11:7 and the opcode in 6:0. The source addresses go straight out to the register file, and the operand data comes back in the same cycle.

When the extension is enabled, an accepted custom word is latched. A one-cycle start pulse goes to the function unit with both operands and both immediates. The pipeline then stalls for as long as the unit takes, with no timeout. After the unit reports done, the 32-bit result is written to the destination register. When the extension is disabled, the same word raises a one-cycle illegal-instruction flag instead. Legality depends only on the opcode and never on funct3 or funct7. An interrupt request that arrives during a stall is held in a sticky pending flag. It is accepted only once the stall has ended, and no new instruction issues while an interrupt is pending.

Top module: `cxi_dispatch`

## Requirements
- R1: One clock edge after a custom word (bits 6:0 = `0001011`) is accepted with `ext_enable` high, `cfu_start` is high and `cfu_funct7`, `cfu_funct3`, `cfu_op_a` and `cfu_op_b` carry bits 31:25, bits 14:12, the `rs1_data` value and the `rs2_data` value. `src1_addr` and `src2_addr` show bits 19:15 and 24:20 of `instr_word` combinationally.
- R2: With the extension enabled, a custom word never raises `illegal_instr`, whatever its funct3 and funct7 values.
- R3: With `ext_enable` low, an accepted custom word gives `illegal_instr` high for exactly one cycle, one edge later, and no start, stall or write.
- R4: A word with any other opcode gives no start, no stall and no illegal flag.
- R5: `stall` rises with `cfu_start` and stays high, with `issue_ready` low, until `cfu_done` is sampled high. A word offered during the stall is ignored.
- R6: One edge after `cfu_done` is sampled during a stall, `stall` falls and `rf_we` pulses for one cycle with `rf_waddr` = bits 11:7 and `rf_wdata` = `cfu_result`. `cfu_done` may already be high in the start cycle.
- R7: A custom instruction whose destination field is zero completes without raising `rf_we`.
- R8: `cfu_start` is high for exactly one cycle per issued custom instruction.
- R9: An `irq_req` pulse during a stall sets `irq_pending` one edge later. The flag stays set, and `irq_take` stays low, until the stall has ended. `irq_take` then pulses for one cycle, one edge after the write-back cycle, and `irq_pending` clears in that same cycle.
- R10: An `irq_req` pulse while idle sets `irq_pending` one edge later and `irq_take` the edge after that. `issue_ready` is low while the flag is set.
- R11: In reset and just after it, `stall`, `cfu_start`, `illegal_instr`, `rf_we`, `irq_pending` and `irq_take` are low and `issue_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_enable | input | 1 | Custom extension enabled |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| issue_ready | output | 1 | Block can accept a word |
| src1_addr | output | 5 | First source register address |
| src2_addr | output | 5 | Second source register address |
| rs1_data | input | 32 | First source operand value |
| rs2_data | input | 32 | Second source operand value |
| stall | output | 1 | Pipeline held for the function unit |
| cfu_start | output | 1 | One-cycle start to the function unit |
| cfu_funct3 | output | 3 | Latched funct3 immediate |
| cfu_funct7 | output | 7 | Latched funct7 immediate |
| cfu_op_a | output | 32 | Latched first operand |
| cfu_op_b | output | 32 | Latched second operand |
| cfu_done | input | 1 | Function unit finished |
| cfu_result | input | 32 | Function unit result |
| illegal_instr | output | 1 | Illegal-instruction pulse |
| rf_we | output | 1 | Destination register write enable |
| rf_waddr | output | 5 | Destination register address |
| rf_wdata | output | 32 | Destination register data |
| irq_req | input | 1 | Interrupt request |
| irq_pending | output | 1 | Sticky pending interrupt |
| irq_take | output | 1 | Interrupt accepted pulse |

## Verification
Every result sits one register from its cause. Start, latched fields and the illegal flag appear one edge after acceptance, the write one edge after done is sampled, the pending flag one edge after the request, and the acceptance one edge after both stall and pending conditions hold. The bench drives inputs and samples outputs on falling edges. It counts the rising edges between a stimulus and its check, so each value is read in the cycle it is due. It also reads the surrounding cycles to confirm that the pulses are one cycle wide and that stall holds across function-unit latencies of 0, 1, 3 and 20 cycles.

// File: rtl/cxi_pkg.sv
package cxi_pkg;
  localparam int INSTR_W = 32;
  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

  typedef struct packed {
    logic [6:0] funct7;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [2:0] funct3;
    logic [4:0] rd;
    logic [6:0] opcode;
  } rtype_t;
endpackage

// File: rtl/cxi_decode.sv
module cxi_decode
  import cxi_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output rtype_t             fields,
  output logic               is_custom
);
  always_comb begin
    fields    = rtype_t'(word);
    is_custom = (fields.opcode == OPC_CUSTOM0);
  end
endmodule

// File: rtl/cxi_seq.sv
module cxi_seq #(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              reject,
  input  logic [2:0]        f3,
  input  logic [6:0]        f7,
  input  logic [RA_W-1:0]   rd,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              done,
  input  logic [DATA_W-1:0] result,
  output logic              start,
  output logic              busy,
  output logic [2:0]        f3_q,
  output logic [6:0]        f7_q,
  output logic [DATA_W-1:0] op_a_q,
  output logic [DATA_W-1:0] op_b_q,
  output logic              illegal,
  output logic              we,
  output logic [RA_W-1:0]   waddr,
  output logic [DATA_W-1:0] wdata
);
  logic [RA_W-1:0] rd_q;
  logic            finish;

  assign finish = busy && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      start   <= 1'b0;
      busy    <= 1'b0;
      illegal <= 1'b0;
      we      <= 1'b0;
      f3_q    <= '0;
      f7_q    <= '0;
      op_a_q  <= '0;
      op_b_q  <= '0;
      rd_q    <= '0;
      waddr   <= '0;
      wdata   <= '0;
    end else begin
      start   <= issue;
      illegal <= reject;
      we      <= finish && (rd_q != '0);
      if (issue) begin
        busy   <= 1'b1;
        f3_q   <= f3;
        f7_q   <= f7;
        op_a_q <= op_a;
        op_b_q <= op_b;
        rd_q   <= rd;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (finish) begin
        waddr <= rd_q;
        wdata <= result;
      end
    end
  end
endmodule

// File: rtl/cxi_irq_hold.sv
module cxi_irq_hold (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic busy,
  output logic pending,
  output logic take
);
  logic accept;

  assign accept = pending && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      take    <= 1'b0;
    end else begin
      pending <= irq_req || (pending && !accept);
      take    <= accept;
    end
  end
endmodule

// File: rtl/cxi_dispatch.sv
module cxi_dispatch
  import cxi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_enable,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  output logic              issue_ready,
  output logic [RA_W-1:0]   src1_addr,
  output logic [RA_W-1:0]   src2_addr,
  input  logic [DATA_W-1:0] rs1_data,
  input  logic [DATA_W-1:0] rs2_data,
  output logic              stall,
  output logic              cfu_start,
  output logic [2:0]        cfu_funct3,
  output logic [6:0]        cfu_funct7,
  output logic [DATA_W-1:0] cfu_op_a,
  output logic [DATA_W-1:0] cfu_op_b,
  input  logic              cfu_done,
  input  logic [DATA_W-1:0] cfu_result,
  output logic              illegal_instr,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic              irq_req,
  output logic              irq_pending,
  output logic              irq_take
);
  rtype_t fld;
  logic   is_custom;
  logic   accept;
  logic   busy;

  cxi_decode u_dec (
    .word      (instr_word),
    .fields    (fld),
    .is_custom (is_custom)
  );

  assign issue_ready = !busy && !irq_pending;
  assign accept      = instr_valid && issue_ready && is_custom;
  assign src1_addr   = fld.rs1;
  assign src2_addr   = fld.rs2;
  assign stall       = busy;

  cxi_seq #(.DATA_W(DATA_W), .RA_W(RA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .issue   (accept && ext_enable),
    .reject  (accept && !ext_enable),
    .f3      (fld.funct3),
    .f7      (fld.funct7),
    .rd      (fld.rd),
    .op_a    (rs1_data),
    .op_b    (rs2_data),
    .done    (cfu_done),
    .result  (cfu_result),
    .start   (cfu_start),
    .busy    (busy),
    .f3_q    (cfu_funct3),
    .f7_q    (cfu_funct7),
    .op_a_q  (cfu_op_a),
    .op_b_q  (cfu_op_b),
    .illegal (illegal_instr),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata)
  );

  cxi_irq_hold u_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .busy    (busy),
    .pending (irq_pending),
    .take    (irq_take)
  );
endmodule

// File: rtl/cxi_dispatch_chk.sv
module cxi_dispatch_chk #(
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            ext_enable,
  input logic            stall,
  input logic            issue_ready,
  input logic            cfu_start,
  input logic            cfu_done,
  input logic            illegal_instr,
  input logic            rf_we,
  input logic [RA_W-1:0] rf_waddr,
  input logic            irq_pending,
  input logic            irq_take
);
  // R8: start pulse is one cycle wide
  assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
    cfu_start |=> !cfu_start);

  // R5: start opens a stall, which holds until done is seen
  assert_start_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    cfu_start |-> stall && !issue_ready);
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (stall && !cfu_done) |=> stall);

  // R2, R3: illegal only when the extension was off at acceptance
  assert_illegal_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    illegal_instr |-> !$past(ext_enable) && !cfu_start);

  // R7: no write to register zero
  assert_no_zero_write_R7: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_waddr != '0);

  // R6: write-back follows the end of a stall
  assert_write_after_stall_R6: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $fell(stall) && !rf_we == 1'b0);

  // R9: interrupt is never accepted while stalled, pulse is single
  assert_take_idle_R9: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !stall && !irq_pending);
  assert_take_single_R9: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);

  // R9: pending survives the stall
  assert_pending_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && stall) |=> irq_pending);
endmodule

bind cxi_dispatch cxi_dispatch_chk #(.RA_W(RA_W)) u_chk (.*);

// File: tb/sim_cxi_dispatch.sv
module sim_cxi_dispatch;
  localparam logic [6:0] CUST = 7'b0001011;

  typedef struct packed {
    logic [31:0] word;
    logic        en;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{ {7'h27, 5'd2, 5'd1, 3'd6, 5'd3, CUST},   1'b1, 32'h00cafe00, 32'h12345678, 32'hdeadbeef, 8'd0 },
    '{ {7'h7f, 5'd31, 5'd30, 3'd7, 5'd31, CUST}, 1'b1, 32'hffffffff, 32'h00000001, 32'ha5a5a5a5, 8'd3 },
    '{ {7'h00, 5'd0, 5'd0, 3'd0, 5'd0, CUST},   1'b1, 32'h11111111, 32'h22222222, 32'h33333333, 8'd1 },
    '{ {7'h15, 5'd4, 5'd5, 3'd2, 5'd6, CUST},   1'b0, 32'h0, 32'h0, 32'h0, 8'd0 },
    '{ {7'h00, 5'd4, 5'd5, 3'd0, 5'd6, 7'b0110011}, 1'b1, 32'h0, 32'h0, 32'h0, 8'd0 },
    '{ {7'h55, 5'd9, 5'd8, 3'd5, 5'd10, CUST},  1'b1, 32'h0badf00d, 32'h5555aaaa, 32'h01234567, 8'd20 }
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_enable = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        issue_ready;
  logic [4:0]  src1_addr, src2_addr;
  logic [31:0] rs1_data = '0, rs2_data = '0;
  logic        stall, cfu_start;
  logic [2:0]  cfu_funct3;
  logic [6:0]  cfu_funct7;
  logic [31:0] cfu_op_a, cfu_op_b;
  logic        cfu_done = 1'b0;
  logic [31:0] cfu_result = '0;
  logic        illegal_instr, rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        irq_req = 1'b0;
  logic        irq_pending, irq_take;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cxi_dispatch u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic run_vec(input vec_t v);
    logic custom;
    custom = (v.word[6:0] == CUST);
    @(negedge clk);
    ext_enable  = v.en;
    instr_valid = 1'b1;
    instr_word  = v.word;
    rs1_data    = v.a;
    rs2_data    = v.b;
    #1;
    chk("R1 src1_addr", 32'(src1_addr), 32'(v.word[19:15]));
    chk("R1 src2_addr", 32'(src2_addr), 32'(v.word[24:20]));
    @(negedge clk);
    instr_valid = 1'b0;
    if (!custom) begin
      chk("R4 start", 32'(cfu_start), 0);
      chk("R4 stall", 32'(stall), 0);
      chk("R4 illegal", 32'(illegal_instr), 0);
    end else if (!v.en) begin
      chk("R3 illegal", 32'(illegal_instr), 1);
      chk("R3 start", 32'(cfu_start), 0);
      chk("R3 stall", 32'(stall), 0);
      @(negedge clk);
      chk("R3 illegal width", 32'(illegal_instr), 0);
      chk("R3 write", 32'(rf_we), 0);
    end else begin
      chk("R1 start", 32'(cfu_start), 1);
      chk("R2 illegal", 32'(illegal_instr), 0);
      chk("R1 funct7", 32'(cfu_funct7), 32'(v.word[31:25]));
      chk("R1 funct3", 32'(cfu_funct3), 32'(v.word[14:12]));
      chk("R1 op_a", cfu_op_a, v.a);
      chk("R1 op_b", cfu_op_b, v.b);
      chk("R5 stall", 32'(stall), 1);
      for (int k = 0; k < int'(v.lat); k++) begin
        @(negedge clk);
        chk("R8 start", 32'(cfu_start), 0);
        chk("R5 stall held", 32'(stall), 1);
        chk("R5 ready low", 32'(issue_ready), 0);
      end
      cfu_done   = 1'b1;
      cfu_result = v.res;
      @(negedge clk);
      cfu_done = 1'b0;
      chk("R6 stall fell", 32'(stall), 0);
      if (v.word[11:7] == 5'd0) begin
        chk("R7 no write", 32'(rf_we), 0);
      end else begin
        chk("R6 write", 32'(rf_we), 1);
        chk("R6 waddr", 32'(rf_waddr), 32'(v.word[11:7]));
        chk("R6 wdata", rf_wdata, v.res);
      end
      @(negedge clk);
      chk("R6 write width", 32'(rf_we), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 stall in reset", 32'(stall), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 stall", 32'(stall), 0);
    chk("R11 start", 32'(cfu_start), 0);
    chk("R11 illegal", 32'(illegal_instr), 0);
    chk("R11 write", 32'(rf_we), 0);
    chk("R11 pending", 32'(irq_pending), 0);
    chk("R11 take", 32'(irq_take), 0);
    chk("R11 ready", 32'(issue_ready), 1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R5: word offered during stall is ignored; R9: interrupt queued
    @(negedge clk);
    ext_enable  = 1'b1;
    instr_valid = 1'b1;
    instr_word  = {7'h01, 5'd1, 5'd1, 3'd1, 5'd7, CUST};
    @(negedge clk);
    chk("R1 start (irq test)", 32'(cfu_start), 1);
    instr_word = {7'h02, 5'd2, 5'd2, 3'd3, 5'd8, CUST};
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk("R5 ignored word", 32'(cfu_start), 0);
    chk("R9 pending set", 32'(irq_pending), 1);
    chk("R9 no take in stall", 32'(irq_take), 0);
    instr_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R9 pending held", 32'(irq_pending), 1);
      chk("R9 take held off", 32'(irq_take), 0);
    end
    cfu_done   = 1'b1;
    cfu_result = 32'hcafef00d;
    @(negedge clk);
    cfu_done = 1'b0;
    chk("R6 waddr (irq test)", 32'(rf_waddr), 7);
    chk("R9 take not yet", 32'(irq_take), 0);
    chk("R9 pending at writeback", 32'(irq_pending), 1);
    @(negedge clk);
    chk("R9 take", 32'(irq_take), 1);
    chk("R9 pending cleared", 32'(irq_pending), 0);
    chk("R5 second word not started", 32'(cfu_start), 0);
    @(negedge clk);
    chk("R9 take width", 32'(irq_take), 0);
    chk("R5 no extra write", 32'(rf_we), 0);

    // R10: interrupt while idle
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk("R10 pending", 32'(irq_pending), 1);
    chk("R10 ready low", 32'(issue_ready), 0);
    chk("R10 take not yet", 32'(irq_take), 0);
    @(negedge clk);
    chk("R10 take", 32'(irq_take), 1);
    chk("R10 pending cleared", 32'(irq_pending), 0);
    chk("R10 ready back", 32'(issue_ready), 1);

    // R11: reset mid-stall clears state
    instr_valid = 1'b1;
    instr_word  = {7'h00, 5'd1, 5'd1, 3'd4, 5'd2, CUST};
    @(negedge clk);
    instr_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 stall after reset", 32'(stall), 0);
    chk("R11 ready after reset", 32'(issue_ready), 1);

    finish_run();
  end
endmodule